// File: doc/BRIEF.md
# Capture-Compare Timer with PWM

This block is a 16-bit free-running timer with two input-capture channels and two output-compare channels, reached through an 8-bit register bus. The counter advances on a tick taken from the system clock divided by 2, 4 or 8, or from a synchronised external clock pin with a selectable active edge. A `halt` input freezes the count. Each capture channel latches the counter on the chosen edge of its pin. Each compare channel fires when the counter steps onto its compare value, and it can drive a programmed level onto its output pin.

Two waveform modes reuse the same units. In single-pulse mode a capture-1 edge restarts the counter and opens a pulse, and compare 1 closes it. In PWM mode compare 1 sets where the output changes level and compare 2 sets the period by reloading the counter. Five status flags drive three interrupt request lines. A flag clears only through a status read followed by an access to the matching data register. Sixteen-bit values are split into high and low bytes. The counter read and the compare write are each kept atomic across the two byte accesses.

Register addresses: 0 control A, 1 control B, 2 status, 3/4 counter high/low, 5/6 capture 1 high/low, 7/8 capture 2 high/low, 9/10 compare 1 high/low, 11/12 compare 2 high/low. Control A holds: bit 7 capture interrupt enable, bit 6 compare interrupt enable, bit 5 overflow interrupt enable, bit 3 capture-2 rising edge, bit 2 capture-1 rising edge, bit 1 level B, bit 0 level A. Control B holds: bit 7 output 1 enable, bit 6 output 2 enable, bit 5 single-pulse mode, bit 4 PWM mode, bits 3:2 clock select, bit 1 external clock on rising edge.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset the counter reads FFFCh, both compare registers read 8000h, status reads 00h, and both output pins and all three interrupt lines are 0.
- R2: Clock select 00/01/10 advances the counter once every 2/4/8 clocks. Clock select 11 advances it once per selected edge of the synchronised external pin. While `halt` is 1 the counter holds.
- R3: A counter step from FFFFh to 0000h sets the overflow flag, which is status bit 5.
- R4: A selected edge on a capture pin latches the counter into that channel's capture register. It sets status bit 7 for channel 1 and bit 4 for channel 2. A clear bit in the control A edge field selects the falling edge.
- R5: In normal mode, when the counter steps onto a compare value, status bit 6 (channel 1) or bit 3 (channel 2) is set. The output register of that channel takes its level bit: level A for channel 1, level B for channel 2. An output pin shows its output register only while its enable bit is set, and shows 0 otherwise.
- R6: A write to a compare high byte disables that channel's matching until its low byte is written.
- R7: A read of the counter high byte freezes the low byte. The next read of the low byte returns the frozen value, and a later read of the low byte returns the live value.
- R8: A flag clears on an access to its data register only if a status read saw it set beforehand. Reads of capture low clear the capture flags. Writes of compare low clear the compare flags. A read of counter low clears overflow. A flag set after the status read survives the access.
- R9: In single-pulse mode, a capture-1 edge loads the counter with FFFCh and drives level B onto output 1. When the counter steps onto compare 1, output 1 takes level A. Edges that arrive while a pulse is open are ignored.
- R10: In PWM mode, output 1 takes level A when the counter steps onto compare 1. When a tick arrives with the counter equal to compare 2, the counter reloads to FFFCh and output 1 takes level B. PWM takes priority over single-pulse mode.
- R11: `irq_cap`, `irq_cmp` and `irq_ovf` are each the OR of their pending flags, gated by their enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_clk_in | input | 1 | External count clock pin |
| cap1_in | input | 1 | Capture channel 1 pin |
| cap2_in | input | 1 | Capture channel 2 pin |
| halt | input | 1 | Freezes the counter |
| oc1_out | output | 1 | Compare channel 1 output pin |
| oc2_out | output | 1 | Compare channel 2 output pin |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The assertions are checked on every cycle. They cover the counter stepping by one or holding, the zero value that follows a wrap, the PWM reload, the spacing of internal ticks and the match of capture values. They also cover the silence of a compare channel during the inhibit window, and the rule that a flag falls only after its own armed access. Only the bench scenarios can show the effects across several registers. These are the correct tick counts per clock setting, the coherence of a counter read split over a running window, and the survival of a flag set after the status read. They also include the ignored retrigger of an open pulse and the complete PWM waveform seen at the output pin.

// File: rtl/cct_pkg.sv
// Shared constants of the capture-compare timer: register addresses,
// clock-select codes and status flag positions.
package cct_pkg;
    localparam int ADDR_W = 4;
    localparam int NCH    = 2;
    localparam int NFLAG  = 5;

    localparam logic [ADDR_W-1:0] A_CTRLA  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRLB  = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_H  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CNT_L  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CAP1_H = 4'd5;
    localparam logic [ADDR_W-1:0] A_CAP1_L = 4'd6;
    localparam logic [ADDR_W-1:0] A_CAP2_H = 4'd7;
    localparam logic [ADDR_W-1:0] A_CAP2_L = 4'd8;
    localparam logic [ADDR_W-1:0] A_CMP1_H = 4'd9;
    localparam logic [ADDR_W-1:0] A_CMP1_L = 4'd10;
    localparam logic [ADDR_W-1:0] A_CMP2_H = 4'd11;
    localparam logic [ADDR_W-1:0] A_CMP2_L = 4'd12;

    localparam logic [1:0] CLK_DIV2 = 2'b00;
    localparam logic [1:0] CLK_DIV4 = 2'b01;
    localparam logic [1:0] CLK_DIV8 = 2'b10;
    localparam logic [1:0] CLK_EXT  = 2'b11;

    // flag vector index == status bit - 3
    localparam int F_CAP1 = 4;
    localparam int F_CMP1 = 3;
    localparam int F_OVF  = 2;
    localparam int F_CAP2 = 1;
    localparam int F_CMP2 = 0;
endpackage

// File: rtl/cct_prescale.sv
// Tick generator. Divides the system clock by 2, 4 or 8 with a free-running
// divider, or detects edges of an external pin after a two-flop synchroniser.
// Assumes the external pin is slower than half the system clock.
module cct_prescale
    import cct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt,
    input  logic [1:0] sel,
    input  logic       ext_rise,
    input  logic       ext_pin,
    output logic       tick
);
    localparam int DIV_W = 3;

    logic [DIV_W-1:0] div_q;
    logic [2:0]       ext_sync_q;
    logic             raw;

    // free-running divider, runs even while halted so phase stays fixed
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // synchroniser and one-cycle history for the external pin
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync_q <= '0;
        else        ext_sync_q <= {ext_sync_q[1:0], ext_pin};
    end

    // pick the tick source
    always_comb begin
        case (sel)
            CLK_DIV2: raw = div_q[0];
            CLK_DIV4: raw = &div_q[1:0];
            CLK_DIV8: raw = &div_q;
            default:  raw = ext_rise ? (ext_sync_q[1] & ~ext_sync_q[2])
                                     : (~ext_sync_q[1] & ext_sync_q[2]);
        endcase
    end

    assign tick = raw & ~halt;

    // R2: an internal tick is never followed at once by another internal tick
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != CLK_EXT) |=> !(tick && sel != CLK_EXT));
endmodule

// File: rtl/cct_capture.sv
// One input-capture channel: synchronises its pin, detects the chosen edge
// and latches the counter value. Emits a one-cycle event with the latch.
module cct_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         rise_sel,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap_q,
    output logic         evt_q
);
    logic [2:0] sync_q;
    logic       edge_hit;

    // synchroniser plus history
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin};
    end

    assign edge_hit = rise_sel ? (sync_q[1] & ~sync_q[2]) : (~sync_q[1] & sync_q[2]);

    // latch the counter on the selected edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= edge_hit;
            if (edge_hit) cap_q <= cnt;
        end
    end

    // R4: the captured value is the counter of the edge cycle
    a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> cap_q == $past(cnt));
endmodule

// File: rtl/cct_wave.sv
// Counter and waveform engine: free-running count, compare matching for both
// channels, single-pulse and PWM sequencing and the output pin registers.
// lvl[0] is level A (compare 1 / pulse end), lvl[1] is level B (start).
module cct_wave
    import cct_pkg::*;
#(
    parameter int           W     = 16,
    parameter logic [W-1:0] START = 16'hFFFC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    trig,
    input  logic                    pwm_en,
    input  logic                    opm_en,
    input  logic [NCH-1:0]          lvl,
    input  logic [NCH-1:0]          cmp_act,
    input  logic [NCH-1:0][W-1:0]   cmp,
    output logic [W-1:0]            cnt_q,
    output logic                    ovf_q,
    output logic [NCH-1:0]          match_q,
    output logic [NCH-1:0]          pin_q
);
    logic [W-1:0]   nxt;
    logic [NCH-1:0] hit;
    logic           busy_q;

    assign nxt = cnt_q + 1'b1;

    // compare hit on the value the counter is about to take
    always_comb begin
        for (int i = 0; i < NCH; i++) hit[i] = cmp_act[i] && (nxt == cmp[i]);
    end

    // count, reload and drive output levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= START;
            busy_q  <= 1'b0;
            pin_q   <= '0;
            match_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            match_q <= '0;
            ovf_q   <= 1'b0;
            if (trig && opm_en && !pwm_en && !busy_q) begin
                cnt_q    <= START;
                pin_q[0] <= lvl[1];
                busy_q   <= 1'b1;
            end else if (tick) begin
                if (pwm_en && cnt_q == cmp[1]) begin
                    cnt_q    <= START;
                    pin_q[0] <= lvl[1];
                end else begin
                    cnt_q <= nxt;
                    ovf_q <= &cnt_q;
                    if (pwm_en) begin
                        if (hit[0]) pin_q[0] <= lvl[0];
                    end else if (opm_en) begin
                        if (busy_q && hit[0]) begin
                            pin_q[0] <= lvl[0];
                            busy_q   <= 1'b0;
                        end
                    end else begin
                        for (int i = 0; i < NCH; i++) begin
                            if (hit[i]) begin
                                match_q[i] <= 1'b1;
                                pin_q[i]   <= lvl[i];
                            end
                        end
                    end
                end
            end
        end
    end

    // R2: no tick and no trigger leaves the counter unchanged
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !trig) |=> $stable(cnt_q));
    // R2: a tick in normal mode steps the counter by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pwm_en && !opm_en) |=> cnt_q == W'($past(cnt_q) + 1'b1));
    // R3: an overflow pulse comes with a zero counter
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> cnt_q == '0);
    // R6: an inhibited channel never matches
    a_r6_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_act[0] |=> !match_q[0]);
    // R10: reaching the period value reloads the start value
    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pwm_en && cnt_q == cmp[1]) |=> cnt_q == START);
endmodule

// File: rtl/cap_cmp_timer.sv
// Top of the capture-compare timer: register bus, control and compare
// registers, status flags with status-read arming, coherent counter read,
// interrupt requests. Assumes one bus strobe per cycle; rdata is combinational.
module cap_cmp_timer
    import cct_pkg::*;
#(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] START   = 16'hFFFC,
    parameter logic [CNT_W-1:0] CMP_RST = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              ext_clk_in,
    input  logic              cap1_in,
    input  logic              cap2_in,
    input  logic              halt,
    output logic              oc1_out,
    output logic              oc2_out,
    output logic              irq_cap,
    output logic              irq_cmp,
    output logic              irq_ovf
);
    localparam int BYTE = 8;
    localparam int HI   = CNT_W - 1;

    logic [7:0]                 ctrla_q, ctrlb_q;
    logic [NCH-1:0][CNT_W-1:0]  cmp_q;
    logic [NCH-1:0]             inh_q;
    logic [NCH-1:0][CNT_W-1:0]  cap_val;
    logic [NCH-1:0]             cap_evt;
    logic [CNT_W-1:0]           cnt;
    logic                       ovf_p;
    logic [NCH-1:0]             match;
    logic [NCH-1:0]             pin;
    logic                       tick;
    logic [NFLAG-1:0]           flag_q, arm_q, set_ev, acc_ev;
    logic [BYTE-1:0]            lo_buf_q;
    logic                       lo_vld_q;
    logic                       stat_rd;
    logic [NCH-1:0]             cap_pins, edge_sel;

    // control, compare registers and compare inhibit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrla_q <= '0;
            ctrlb_q <= '0;
            cmp_q   <= {NCH{CMP_RST}};
            inh_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRLA:  ctrla_q <= bus_wdata;
                A_CTRLB:  ctrlb_q <= bus_wdata;
                A_CMP1_H: begin cmp_q[0][HI:BYTE] <= bus_wdata; inh_q[0] <= 1'b1; end
                A_CMP1_L: begin cmp_q[0][BYTE-1:0] <= bus_wdata; inh_q[0] <= 1'b0; end
                A_CMP2_H: begin cmp_q[1][HI:BYTE] <= bus_wdata; inh_q[1] <= 1'b1; end
                A_CMP2_L: begin cmp_q[1][BYTE-1:0] <= bus_wdata; inh_q[1] <= 1'b0; end
                default: ;
            endcase
        end
    end

    cct_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .halt(halt), .sel(ctrlb_q[3:2]),
        .ext_rise(ctrlb_q[1]), .ext_pin(ext_clk_in), .tick(tick)
    );

    assign cap_pins = {cap2_in, cap1_in};
    assign edge_sel = {ctrla_q[3], ctrla_q[2]};

    for (genvar g = 0; g < NCH; g++) begin : g_cap
        cct_capture #(.W(CNT_W)) u_cap (
            .clk(clk), .rst_n(rst_n), .pin(cap_pins[g]), .rise_sel(edge_sel[g]),
            .cnt(cnt), .cap_q(cap_val[g]), .evt_q(cap_evt[g])
        );
    end

    cct_wave #(.W(CNT_W), .START(START)) u_wave (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trig(cap_evt[0]),
        .pwm_en(ctrlb_q[4]), .opm_en(ctrlb_q[5]), .lvl(ctrla_q[1:0]),
        .cmp_act(~inh_q), .cmp(cmp_q), .cnt_q(cnt), .ovf_q(ovf_p),
        .match_q(match), .pin_q(pin)
    );

    assign stat_rd = bus_rd && bus_addr == A_STAT;
    assign set_ev  = {cap_evt[0], match[0], ovf_p, cap_evt[1], match[1]};
    assign acc_ev  = {bus_rd && bus_addr == A_CAP1_L,
                      bus_wr && bus_addr == A_CMP1_L,
                      bus_rd && bus_addr == A_CNT_L,
                      bus_rd && bus_addr == A_CAP2_L,
                      bus_wr && bus_addr == A_CMP2_L};

    // flags: set by events, cleared by an armed data access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            arm_q  <= '0;
        end else begin
            flag_q <= set_ev | (flag_q & ~(acc_ev & arm_q));
            arm_q  <= stat_rd ? flag_q : (arm_q & ~acc_ev);
        end
    end

    // low-byte buffer for a coherent counter read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_buf_q <= '0;
            lo_vld_q <= 1'b0;
        end else if (bus_rd && bus_addr == A_CNT_H) begin
            lo_buf_q <= cnt[BYTE-1:0];
            lo_vld_q <= 1'b1;
        end else if (bus_rd && bus_addr == A_CNT_L) begin
            lo_vld_q <= 1'b0;
        end
    end

    // read data multiplexer
    always_comb begin
        case (bus_addr)
            A_CTRLA:  bus_rdata = ctrla_q;
            A_CTRLB:  bus_rdata = ctrlb_q;
            A_STAT:   bus_rdata = {flag_q, 3'b000};
            A_CNT_H:  bus_rdata = cnt[HI:BYTE];
            A_CNT_L:  bus_rdata = lo_vld_q ? lo_buf_q : cnt[BYTE-1:0];
            A_CAP1_H: bus_rdata = cap_val[0][HI:BYTE];
            A_CAP1_L: bus_rdata = cap_val[0][BYTE-1:0];
            A_CAP2_H: bus_rdata = cap_val[1][HI:BYTE];
            A_CAP2_L: bus_rdata = cap_val[1][BYTE-1:0];
            A_CMP1_H: bus_rdata = cmp_q[0][HI:BYTE];
            A_CMP1_L: bus_rdata = cmp_q[0][BYTE-1:0];
            A_CMP2_H: bus_rdata = cmp_q[1][HI:BYTE];
            A_CMP2_L: bus_rdata = cmp_q[1][BYTE-1:0];
            default:  bus_rdata = '0;
        endcase
    end

    assign oc1_out = ctrlb_q[7] & pin[0];
    assign oc2_out = ctrlb_q[6] & pin[1];
    assign irq_cap = ctrla_q[7] & (flag_q[F_CAP1] | flag_q[F_CAP2]);
    assign irq_cmp = ctrla_q[6] & (flag_q[F_CMP1] | flag_q[F_CMP2]);
    assign irq_ovf = ctrla_q[5] & flag_q[F_OVF];

    // R8: capture-1 flag falls only after a capture-1 low read
    a_r8_cap1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[F_CAP1]) |-> $past(bus_rd && bus_addr == A_CAP1_L));
    // R8: overflow flag falls only if a status read armed it
    a_r8_ovf_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[F_OVF]) |-> $past(arm_q[F_OVF]));
    // R7: the frozen low byte survives until the low byte is read
    a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_vld_q && !bus_rd) |=> (lo_vld_q && $stable(lo_buf_q)));
endmodule

// File: tb/cap_cmp_timer_tb.sv
// Scoreboard bench: read tasks queue the expected byte, a monitor pops and
// compares it while the read strobe is high.
module cap_cmp_timer_tb;
    import cct_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_rdata;
    logic              ext_clk_in = 1'b0;
    logic              cap1_in = 1'b0;
    logic              cap2_in = 1'b0;
    logic              halt = 1'b1;
    logic              oc1_out, oc2_out, irq_cap, irq_cmp, irq_ovf;

    int   n_checks = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    exp_t cur;

    cap_cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_clk_in(ext_clk_in), .cap1_in(cap1_in), .cap2_in(cap2_in),
        .halt(halt), .oc1_out(oc1_out), .oc2_out(oc2_out),
        .irq_cap(irq_cap), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: samples a quarter period before the edge that ends the read
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                check(bus_rdata, 8'h00, "scoreboard empty");
            end else begin
                cur = sb_q.pop_front();
                check(bus_rdata, cur.exp, cur.tag);
            end
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run(input int k);
        halt = 1'b0;
        repeat (k) @(negedge clk);
        halt = 1'b1;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pin_chk(input logic act, input logic exp, input string tag);
        check({7'd0, act}, {7'd0, exp}, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd_exp(A_STAT, 8'h00, "R1 status");
        rd_exp(A_CNT_H, 8'hFF, "R1 counter high");
        rd_exp(A_CNT_L, 8'hFC, "R1 counter low");
        rd_exp(A_CMP1_H, 8'h80, "R1 compare1 high");
        rd_exp(A_CMP2_H, 8'h80, "R1 compare2 high");
        pin_chk(oc1_out, 1'b0, "R1 oc1");
        pin_chk(irq_ovf | irq_cap | irq_cmp, 1'b0, "R1 irq");

        // R3 overflow after 8 ticks at /2: FFFC -> 0004
        run(16);
        rd_exp(A_STAT, 8'h20, "R3 overflow flag");
        pin_chk(irq_ovf, 1'b0, "R11 ovf irq masked");
        wr_reg(A_CTRLA, 8'h20);
        pin_chk(irq_ovf, 1'b1, "R11 ovf irq enabled");
        rd_exp(A_CNT_H, 8'h00, "R7 counter high");
        rd_exp(A_CNT_L, 8'h04, "R2 counter after div2");
        rd_exp(A_STAT, 8'h00, "R8 overflow cleared");
        pin_chk(irq_ovf, 1'b0, "R11 ovf irq cleared");

        // R5 compare 1 at 000A, level A = 1
        wr_reg(A_CMP1_H, 8'h00);
        wr_reg(A_CMP1_L, 8'h0A);
        wr_reg(A_CTRLA, 8'h21);
        wr_reg(A_CTRLB, 8'h80);
        pin_chk(oc1_out, 1'b0, "R5 oc1 before match");
        run(16);
        rd_exp(A_STAT, 8'h40, "R5 compare1 flag");
        pin_chk(oc1_out, 1'b1, "R5 oc1 level");
        pin_chk(oc2_out, 1'b0, "R5 oc2 disabled");
        wr_reg(A_CMP1_L, 8'h10);

        // R6 inhibit: high byte alone keeps channel silent
        wr_reg(A_CMP1_H, 8'h00);
        run(16);
        rd_exp(A_STAT, 8'h00, "R6 inhibited no flag");
        wr_reg(A_CMP1_L, 8'h18);
        run(16);
        rd_exp(A_STAT, 8'h40, "R6 active after low write");
        wr_reg(A_CMP1_L, 8'h18);
        rd_exp(A_STAT, 8'h00, "R8 compare1 cleared");

        // R4 capture, counter 001C
        wr_reg(A_CTRLA, 8'hAD);
        cap1_in = 1'b1;
        idle(6);
        rd_exp(A_STAT, 8'h80, "R4 capture1 flag");
        pin_chk(irq_cap, 1'b1, "R11 cap irq");
        rd_exp(A_CAP1_H, 8'h00, "R4 capture1 high");
        rd_exp(A_CAP1_L, 8'h1C, "R4 capture1 low");
        cap2_in = 1'b1;
        idle(6);
        rd_exp(A_CAP2_L, 8'h1C, "R4 capture2 low");
        rd_exp(A_STAT, 8'h10, "R8 unarmed flag survives");
        rd_exp(A_CAP2_L, 8'h1C, "R4 capture2 low again");
        rd_exp(A_STAT, 8'h00, "R8 capture2 cleared");
        pin_chk(irq_cap, 1'b0, "R11 cap irq cleared");

        // R4 falling edge on channel 1
        wr_reg(A_CTRLA, 8'hA9);
        run(4);
        cap1_in = 1'b0;
        idle(6);
        rd_exp(A_STAT, 8'h80, "R4 falling flag");
        rd_exp(A_CAP1_L, 8'h1E, "R4 falling value");
        rd_exp(A_STAT, 8'h00, "R8 capture1 cleared");

        // R7 coherent read across a running window
        rd_exp(A_CNT_H, 8'h00, "R7 high");
        run(16);
        rd_exp(A_CNT_L, 8'h1E, "R7 frozen low");
        rd_exp(A_CNT_L, 8'h26, "R7 live low");

        // R2 other divisors and external clock
        wr_reg(A_CTRLB, 8'h84);
        run(16);
        rd_exp(A_CNT_L, 8'h2A, "R2 div4");
        wr_reg(A_CTRLB, 8'h88);
        run(16);
        rd_exp(A_CNT_L, 8'h2C, "R2 div8");
        wr_reg(A_CTRLB, 8'h8E);
        halt = 1'b0;
        for (int i = 0; i < 3; i++) begin
            ext_clk_in = 1'b1; idle(4);
            ext_clk_in = 1'b0; idle(4);
        end
        halt = 1'b1;
        rd_exp(A_CNT_L, 8'h2F, "R2 external edges");
        idle(10);
        rd_exp(A_CNT_L, 8'h2F, "R2 halt holds");

        // R9 single pulse: start level B=1, end level A=0, end at 0001
        wr_reg(A_CTRLA, 8'hA6);
        wr_reg(A_CMP1_H, 8'h00);
        wr_reg(A_CMP1_L, 8'h01);
        wr_reg(A_CTRLB, 8'hA0);
        cap1_in = 1'b1;
        idle(6);
        pin_chk(oc1_out, 1'b1, "R9 pulse start level");
        rd_exp(A_CNT_H, 8'hFF, "R9 reload high");
        rd_exp(A_CNT_L, 8'hFC, "R9 reload low");
        run(4);
        cap1_in = 1'b0; idle(3);
        cap1_in = 1'b1; idle(6);
        rd_exp(A_CNT_H, 8'hFF, "R9 retrigger ignored high");
        rd_exp(A_CNT_L, 8'hFE, "R9 retrigger ignored low");
        run(16);
        pin_chk(oc1_out, 1'b0, "R9 pulse end level");

        // R10 PWM: level change at FFFE, period ends at 0001
        wr_reg(A_CMP1_H, 8'hFF);
        wr_reg(A_CMP1_L, 8'hFE);
        wr_reg(A_CMP2_H, 8'h00);
        wr_reg(A_CMP2_L, 8'h01);
        cap1_in = 1'b0; idle(3);
        cap1_in = 1'b1; idle(6);
        pin_chk(oc1_out, 1'b1, "R10 start level");
        wr_reg(A_CTRLB, 8'hB0);
        run(4);
        pin_chk(oc1_out, 1'b0, "R10 level at compare1");
        rd_exp(A_CNT_H, 8'hFF, "R10 count high");
        rd_exp(A_CNT_L, 8'hFE, "R10 count low");
        run(6);
        pin_chk(oc1_out, 1'b0, "R10 level held");
        rd_exp(A_CNT_L, 8'h01, "R10 at period");
        run(2);
        pin_chk(oc1_out, 1'b1, "R10 level after reload");
        rd_exp(A_CNT_H, 8'hFF, "R10 reload high");
        rd_exp(A_CNT_L, 8'hFC, "R10 reload low");

        idle(2);
        if (sb_q.size() != 0) check(8'(sb_q.size()), 8'h00, "scoreboard leftovers");
        done = 1'b1;
        finish_run();
    end
endmodule